// File: doc/BRIEF.md
# Nonvolatile Store/Recall Controller

This controller sits beside a volatile SRAM array and its shadow nonvolatile copy. It decides when data moves between the two and blocks normal SRAM access while a transfer is running. A single digital supply-good input stands in for the analog power monitor. When the supply comes back, the controller copies the nonvolatile contents into the SRAM. When the supply drops, it copies the SRAM into the nonvolatile array, but only if the SRAM has changed. Software can also request a copy to the nonvolatile array at any time the part is ready.

Each copy to the nonvolatile array runs in two timed phases: an erase phase followed by a program phase. A copy back into the SRAM runs as one timed phase. A dirty flag records whether any write has been accepted since the last transfer. After a power-up copy into the SRAM, a write request that was already held during that copy stays blocked until the requester lets a strobe go inactive and then asserts it again. The phase lengths are parameters counted in clock cycles.

Top module: `nv_xfer_ctrl`

## Requirements
- R1: While reset is asserted, and afterwards until the supply-good input is seen high, all outputs are low.
- R2: In the powered-down idle state, a high supply-good input starts a recall on the next clock. `recall_o` then stays high for exactly RCL_CYC cycles.
- R3: When a recall or a store finishes, the controller enters the ready state (`acc_en_o` high) if supply-good is high, and otherwise enters powered-down idle. A finished recall leaves `dirty_o` low.
- R4: A recall may end with both `ce_i` and `we_i` high at that clock. In that case `wr_en_o` stays low until at least one of the two strobes has been sampled low, and the pair is active together again.
- R5: In the ready state, if supply-good goes low while `dirty_o` is low and no software request is present, the controller returns to powered-down idle without asserting `erase_o`.
- R6: In the ready state, if supply-good goes low while `dirty_o` is high, a store starts. A store is `erase_o` high for ERS_CYC cycles, followed immediately by `program_o` high for PRG_CYC cycles.
- R7: A `sw_store_i` pulse seen in the ready state starts a store whatever `dirty_o` is. This also holds when supply-good falls in the same cycle.
- R8: While `busy_o` is high (any recall, erase or program phase), `acc_en_o` and `wr_en_o` are low.
- R9: `wr_en_o` is `acc_en_o & ce_i & we_i`, masked by the lockout of R4. A cycle with `wr_en_o` high sets `dirty_o` from the next cycle. The end of a store clears `dirty_o`.
- R10: At most one of `erase_o`, `program_o` and `recall_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwr_good_i | input | 1 | Supply is above the switch threshold |
| ce_i | input | 1 | Chip-enable strobe, active high |
| we_i | input | 1 | Write-enable strobe, active high |
| sw_store_i | input | 1 | Software store request, one-cycle pulse |
| acc_en_o | output | 1 | SRAM read/write port enabled (ready state) |
| wr_en_o | output | 1 | SRAM write accepted this cycle |
| erase_o | output | 1 | Nonvolatile erase phase active |
| program_o | output | 1 | Nonvolatile program phase active |
| recall_o | output | 1 | Nonvolatile-to-SRAM recall phase active |
| busy_o | output | 1 | A transfer is running |
| dirty_o | output | 1 | SRAM written since last store or recall |

## Verification
A software store request and a supply drop can land on the same ready-state clock. The bench forces this while the dirty flag is clear, which is the case where the power-loss path on its own would skip the store. The correct result is an erase phase on the next cycle. A recall can also end on the same clock that a held write is presented. The bench keeps both strobes high through the whole power-up recall and checks that the first write is accepted only after a strobe has dropped and returned. Constrained random traffic then lets both kinds of collision happen at arbitrary points. Every output is compared each cycle against a reference model built in the bench from the requirements.

// File: rtl/nvx_pkg.sv
package nvx_pkg;
  typedef enum logic [2:0] {
    NVX_OFF    = 3'd0,
    NVX_RECALL = 3'd1,
    NVX_READY  = 3'd2,
    NVX_ERASE  = 3'd3,
    NVX_PROG   = 3'd4
  } nvx_state_e;

  function automatic int unsigned nvx_max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/nvx_rst_sync.sv
module nvx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;
endmodule

// File: rtl/nvx_phase_timer.sv
module nvx_phase_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/nvx_dirty_track.sv
module nvx_dirty_track (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_hit,
  input  logic xfer_end,
  output logic dirty
);
  logic dirty_q;
  logic dirty_d;
  logic dirty_en;

  always_comb begin
    dirty_en = wr_hit || xfer_end;
    dirty_d  = !xfer_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dirty_q <= 1'b0;
    end else if (dirty_en) begin
      dirty_q <= dirty_d;
    end
  end

  assign dirty = dirty_q;
endmodule

// File: rtl/nvx_wr_lock.sv
module nvx_wr_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic recall_end,
  input  logic ce,
  input  logic we,
  output logic locked
);
  logic lock_q;
  logic lock_d;
  logic lock_en;
  logic pair_on;

  always_comb begin
    pair_on = ce && we;
    lock_en = (recall_end && pair_on) || !pair_on;
    lock_d  = recall_end && pair_on;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
    end else if (lock_en) begin
      lock_q <= lock_d;
    end
  end

  assign locked = lock_q;
endmodule

// File: rtl/nv_xfer_ctrl.sv
module nv_xfer_ctrl
  import nvx_pkg::*;
#(
  parameter int unsigned RCL_CYC = 64,
  parameter int unsigned ERS_CYC = 32,
  parameter int unsigned PRG_CYC = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good_i,
  input  logic ce_i,
  input  logic we_i,
  input  logic sw_store_i,
  output logic acc_en_o,
  output logic wr_en_o,
  output logic erase_o,
  output logic program_o,
  output logic recall_o,
  output logic busy_o,
  output logic dirty_o
);
  localparam int unsigned MAXC = nvx_max3(RCL_CYC, ERS_CYC, PRG_CYC);
  localparam int unsigned CW   = (MAXC < 2) ? 1 : $clog2(MAXC);
  localparam logic [CW-1:0] RCL_LD = CW'(RCL_CYC - 1);
  localparam logic [CW-1:0] ERS_LD = CW'(ERS_CYC - 1);
  localparam logic [CW-1:0] PRG_LD = CW'(PRG_CYC - 1);

  logic       rst_sync_n;
  nvx_state_e state_q;
  nvx_state_e state_d;
  logic       tmr_done;
  logic       tmr_load;
  logic [CW-1:0] tmr_val;
  logic       dirty;
  logic       locked;
  logic       recall_end;
  logic       xfer_end;
  logic       wr_hit;

  nvx_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // next-state decision
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      NVX_OFF: begin
        if (pwr_good_i) state_d = NVX_RECALL;
      end
      NVX_RECALL: begin
        if (tmr_done) state_d = pwr_good_i ? NVX_READY : NVX_OFF;
      end
      NVX_READY: begin
        if (sw_store_i || (!pwr_good_i && dirty)) state_d = NVX_ERASE;
        else if (!pwr_good_i)                    state_d = NVX_OFF;
      end
      NVX_ERASE: begin
        if (tmr_done) state_d = NVX_PROG;
      end
      NVX_PROG: begin
        if (tmr_done) state_d = pwr_good_i ? NVX_READY : NVX_OFF;
      end
      default: state_d = NVX_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= NVX_OFF;
    end else begin
      state_q <= state_d;
    end
  end

  // phase timer reload on every state change
  always_comb begin
    tmr_load = (state_d != state_q);
    unique case (state_d)
      NVX_RECALL: tmr_val = RCL_LD;
      NVX_ERASE:  tmr_val = ERS_LD;
      NVX_PROG:   tmr_val = PRG_LD;
      default:    tmr_val = '0;
    endcase
  end

  nvx_phase_timer #(.W(CW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  always_comb begin
    recall_end = (state_q == NVX_RECALL) && tmr_done;
    xfer_end   = tmr_done && ((state_q == NVX_RECALL) || (state_q == NVX_PROG));
    wr_hit     = (state_q == NVX_READY) && ce_i && we_i && !locked;
  end

  nvx_wr_lock u_lock (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .recall_end (recall_end && pwr_good_i),
    .ce         (ce_i),
    .we         (we_i),
    .locked     (locked)
  );

  nvx_dirty_track u_dirty (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_hit   (wr_hit),
    .xfer_end (xfer_end),
    .dirty    (dirty)
  );

  assign acc_en_o  = (state_q == NVX_READY);
  assign wr_en_o   = wr_hit;
  assign erase_o   = (state_q == NVX_ERASE);
  assign program_o = (state_q == NVX_PROG);
  assign recall_o  = (state_q == NVX_RECALL);
  assign busy_o    = recall_o || erase_o || program_o;
  assign dirty_o   = dirty;
endmodule

// File: rtl/nv_xfer_ctrl_chk.sv
module nv_xfer_ctrl_chk (
  input logic clk,
  input logic rst_ok,
  input logic pwr_good_i,
  input logic ce_i,
  input logic we_i,
  input logic sw_store_i,
  input logic acc_en_o,
  input logic wr_en_o,
  input logic erase_o,
  input logic program_o,
  input logic recall_o,
  input logic busy_o,
  input logic dirty_o
);
  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_ok)
    $onehot0({erase_o, program_o, recall_o})); // R10

  AST_BUSY_GATES_PORT: assert property (@(posedge clk) disable iff (!rst_ok)
    busy_o |-> (!acc_en_o && !wr_en_o)); // R8

  AST_OFF_STARTS_RECALL: assert property (@(posedge clk) disable iff (!rst_ok)
    (!busy_o && !acc_en_o && pwr_good_i) |=> recall_o); // R2

  AST_RECALL_CLEAN: assert property (@(posedge clk) disable iff (!rst_ok)
    $fell(recall_o) |-> !dirty_o); // R3

  AST_LOCK_HELD_WRITE: assert property (@(posedge clk) disable iff (!rst_ok)
    ($fell(recall_o) && acc_en_o && $past(ce_i && we_i)) |-> !wr_en_o); // R4

  AST_CLEAN_LOSS_SKIPS: assert property (@(posedge clk) disable iff (!rst_ok)
    (acc_en_o && !pwr_good_i && !sw_store_i && !dirty_o) |=> (!erase_o && !busy_o)); // R5

  AST_ERASE_THEN_PROG: assert property (@(posedge clk) disable iff (!rst_ok)
    $fell(erase_o) |-> program_o); // R6

  AST_PROG_AFTER_ERASE: assert property (@(posedge clk) disable iff (!rst_ok)
    $rose(program_o) |-> $past(erase_o)); // R6

  AST_SW_STORE_RUNS: assert property (@(posedge clk) disable iff (!rst_ok)
    (acc_en_o && sw_store_i) |=> erase_o); // R7

  AST_WRITE_MARKS: assert property (@(posedge clk) disable iff (!rst_ok)
    wr_en_o |=> dirty_o); // R9

  AST_STORE_CLEANS: assert property (@(posedge clk) disable iff (!rst_ok)
    $fell(program_o) |-> !dirty_o); // R9
endmodule

bind nv_xfer_ctrl nv_xfer_ctrl_chk u_chk (
  .clk        (clk),
  .rst_ok     (rst_sync_n),
  .pwr_good_i (pwr_good_i),
  .ce_i       (ce_i),
  .we_i       (we_i),
  .sw_store_i (sw_store_i),
  .acc_en_o   (acc_en_o),
  .wr_en_o    (wr_en_o),
  .erase_o    (erase_o),
  .program_o  (program_o),
  .recall_o   (recall_o),
  .busy_o     (busy_o),
  .dirty_o    (dirty_o)
);

// File: tb/nv_xfer_ctrl_test.sv
module nv_xfer_ctrl_test;
  localparam int RCL = 5;
  localparam int ERS = 3;
  localparam int PRG = 4;
  localparam int S_OFF = 0, S_RCL = 1, S_RDY = 2, S_ERS = 3, S_PRG = 4;

  logic clk;
  logic rst_n;
  logic pg, ce, we, sw;
  logic acc_en, wr_en, erase, prog, recall, busy, dirty;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit run   = 0;

  int m_st, m_cnt;
  bit m_dirty, m_lock;

  nv_xfer_ctrl #(.RCL_CYC(RCL), .ERS_CYC(ERS), .PRG_CYC(PRG)) uut (
    .clk(clk), .rst_n(rst_n), .pwr_good_i(pg), .ce_i(ce), .we_i(we),
    .sw_store_i(sw), .acc_en_o(acc_en), .wr_en_o(wr_en), .erase_o(erase),
    .program_o(prog), .recall_o(recall), .busy_o(busy), .dirty_o(dirty)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog: run did not end, act=%0d exp<=100000", cyc);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  function automatic int phase_len(int s);
    case (s)
      S_RCL:   return RCL;
      S_ERS:   return ERS;
      S_PRG:   return PRG;
      default: return 1;
    endcase
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: act=%0d exp=%0d", req, what, cyc, act, exp);
    end
  endtask

  // reference model: one clock edge with the inputs that edge sampled
  task automatic model_step();
    bit wr, done;
    int nst;
    wr   = (m_st == S_RDY) && ce && we && !m_lock;
    done = (m_cnt == 0);
    nst  = m_st;
    case (m_st)
      S_OFF: if (pg) nst = S_RCL;
      S_RCL: if (done) nst = pg ? S_RDY : S_OFF;
      S_RDY: if (sw || (!pg && m_dirty)) nst = S_ERS;
             else if (!pg) nst = S_OFF;
      S_ERS: if (done) nst = S_PRG;
      S_PRG: if (done) nst = pg ? S_RDY : S_OFF;
      default: nst = S_OFF;
    endcase
    if (m_st == S_RCL && done && pg && ce && we) m_lock = 1;
    else if (!(ce && we)) m_lock = 0;
    if ((m_st == S_RCL || m_st == S_PRG) && done) m_dirty = 0;
    else if (wr) m_dirty = 1;
    if (nst != m_st) m_cnt = phase_len(nst) - 1;
    else if (m_cnt != 0) m_cnt--;
    m_st = nst;
  endtask

  task automatic compare_all();
    bit e_acc;
    e_acc = (m_st == S_RDY);
    chk("R8", "acc_en_o", int'(acc_en), int'(e_acc));
    chk("R4", "wr_en_o", int'(wr_en), int'(e_acc && ce && we && !m_lock));
    chk("R6", "erase_o", int'(erase), int'(m_st == S_ERS));
    chk("R6", "program_o", int'(prog), int'(m_st == S_PRG));
    chk("R2", "recall_o", int'(recall), int'(m_st == S_RCL));
    chk("R8", "busy_o", int'(busy), int'(m_st == S_RCL || m_st == S_ERS || m_st == S_PRG));
    chk("R9", "dirty_o", int'(dirty), int'(m_dirty));
  endtask

  task automatic tick(bit n_pg, bit n_ce, bit n_we, bit n_sw);
    @(negedge clk);
    if (run) model_step();
    pg = n_pg; ce = n_ce; we = n_we; sw = n_sw;
    #1;
    if (run) compare_all();
  endtask

  task automatic reach_ready();
    for (int i = 0; i < 40 && !acc_en; i++) tick(1, 0, 0, 0);
  endtask

  initial begin
    void'($urandom(32'h2c41));
    m_st = S_OFF; m_cnt = 0; m_dirty = 0; m_lock = 0;
    pg = 0; ce = 0; we = 0; sw = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "busy_o in reset", int'(busy), 0);
    chk("R1", "acc_en_o in reset", int'(acc_en), 0);
    chk("R1", "dirty_o in reset", int'(dirty), 0);
    chk("R1", "strobes in reset", int'({erase, prog, recall}), 0);
    @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 4; i++) tick(0, 1, 1, 0);
    chk("R1", "idle after release, supply low", int'({acc_en, busy, wr_en}), 0);
    run = 1;

    // R4: both strobes held through power-up recall
    for (int i = 0; i < RCL + 2; i++) tick(1, 1, 1, 0);
    chk("R4", "held write blocked after recall", int'(wr_en), 0);
    chk("R3", "ready after recall", int'(acc_en), 1);
    tick(1, 1, 0, 0);
    tick(1, 1, 1, 0);
    chk("R4", "write accepted after re-strobe", int'(wr_en), 1);
    tick(1, 0, 0, 0);
    chk("R9", "dirty after write", int'(dirty), 1);

    // R6: dirty power loss runs a store
    tick(0, 0, 0, 0);
    tick(0, 0, 0, 0);
    chk("R6", "erase after dirty loss", int'(erase), 1);
    for (int i = 0; i < ERS + PRG; i++) tick(0, 0, 0, 0);
    chk("R3", "off after store with supply low", int'({acc_en, busy}), 0);
    chk("R9", "store clears dirty", int'(dirty), 0);

    // R5: clean power loss skips the store
    reach_ready();
    tick(0, 0, 0, 0);
    tick(0, 0, 0, 0);
    chk("R5", "no erase on clean loss", int'(erase), 0);
    chk("R5", "idle on clean loss", int'({acc_en, busy}), 0);

    // R7: software store and power loss in the same cycle, dirty clear
    reach_ready();
    tick(0, 0, 0, 1);
    tick(0, 0, 0, 0);
    chk("R7", "sw store wins over clean loss", int'(erase), 1);
    for (int i = 0; i < ERS + PRG + 2; i++) tick(1, 0, 0, 0);

    // R7: software store with supply good, dirty clear
    reach_ready();
    tick(1, 0, 0, 1);
    tick(1, 1, 1, 0);
    chk("R7", "sw store on clean array", int'(erase), 1);
    chk("R8", "write gated in store", int'(wr_en), 0);

    // constrained random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      bit npg;
      npg = ($urandom_range(99) < 4) ? !pg : pg;
      tick(npg, $urandom_range(99) < 70, $urandom_range(99) < 50, $urandom_range(99) < 3);
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule